// File: doc/BRIEF.md
# Dual-Point PWM Channel Generator

This block produces one pulse-width-modulated output. A time quantum comes from a two-stage prescaler: a linear divide by (L + 1), followed by a left shift of S bits. An 8-bit quantum counter runs from 0 up to a programmed period value and then returns to 0, so one PWM period lasts (period + 1) quanta. The output is active while the counter lies inside a window set by two 8-bit points, a rise point and a fall point. The window wraps around the period end when the rise point is larger than the fall point. When the two points are equal, the output is active for the whole period.

Configuration arrives through a simple write port with two register slots. Clock and control settings apply as soon as they are written. The divisor and waveform fields (period and points) go first into a staging bank. They are copied to the working bank at the next period boundary, so a period never mixes settings. A sync-off control bit makes them copy through at once instead. While the counter is stopped, the working bank follows the staging bank.

The output stage applies, in this order: pin gating, then polarity inversion, then push-pull or open-drain drive. A status pin shows the raw waveform level before gating and inversion.

Top module: `pwm_dual_point_ch`

## Requirements
- R1: One quantum lasts (L + 1) << S clock cycles. L is wr_data[7:0] and S is wr_data[11:8] of slot 0 (wr_sel = 0). While the counter runs, the quantum counter advances once per quantum.
- R2: The period value is wr_data[23:16] of slot 1 (wr_sel = 1). The quantum counter counts 0..period and then wraps to 0, so one period lasts (period + 1) quanta.
- R3: The rise point is wr_data[7:0] and the fall point is wr_data[15:8] of slot 1. With rise < fall, the level is 1 for counts rise ≤ q < fall. With rise > fall, the level is 1 for q ≥ rise or q < fall.
- R4: When the rise point equals the fall point, the level is 1 for every count of the period.
- R5: The run bit is slot 0 bit 12. While it is 0, the prescaler and quantum counter are held at 0 and the level is 0. Slot 1 may still be written, and after run is set the counting restarts at count 0 with the latest values.
- R6: The pin-enable bit is slot 0 bit 13. When it is 0, pwm_o carries the inactive level (equal to the invert bit) and pwm_oe_o is 0. This takes effect in the cycle after the write, without waiting for the period to end, and the counter keeps running.
- R7: The invert bit is slot 0 bit 14. pwm_o is the gated level XOR invert, and a change of invert shows on pwm_o in the cycle after the write.
- R8: With sync-off 0, a write of slot 1 during a running period leaves that period unchanged. The new values apply from the next period, which starts after the count equals period and a quantum ends.
- R9: The sync-off bit is slot 0 bit 16. When it is 1, slot 1 and divisor writes take effect in the cycle after the write.
- R10: The open-drain bit is slot 0 bit 15. When it is 1 and the pin is enabled, pwm_oe_o is 1 only while pwm_o is 0.
- R11: With open-drain 0 and the pin enabled, pwm_oe_o is 1 whatever the level.
- R12: After reset, pwm_o, pwm_oe_o and stat_level_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | Slot select: 0 clock/control, 1 waveform |
| wr_data | input | 24 | Write data |
| pwm_o | output | 1 | Output data value after gating and inversion |
| pwm_oe_o | output | 1 | Output enable (status and pad control) |
| stat_level_o | output | 1 | Raw waveform level before gating and inversion |

## Verification
Some assertions rely on stable inputs. The prescaler bound holds only while the divisor stays unchanged. The shadow-hold property is conditioned on cycles with no write. The stimulus changes divisor and waveform only while the counter is stopped, or through the staging path with sync-off clear. The single sync-off case moves the fall point without shrinking the period below the current count. The sweeps cover small divisors and periods, so each case finishes in a few dozen cycles, and the bench computes every expected level from the count and the window rule.

// File: rtl/pwm_dp_pkg.sv
package pwm_dp_pkg;

    parameter int LIN_W  = 8;
    parameter int SHF_W  = 4;
    parameter int CNT_W  = 8;
    parameter int CTRL_W = 5;

    localparam int CTRL_BASE = LIN_W + SHF_W;
    localparam int WAVE_W    = 3 * CNT_W;
    localparam int DATA_W    = (WAVE_W > CTRL_BASE + CTRL_W) ? WAVE_W : CTRL_BASE + CTRL_W;
    localparam int PRE_W     = LIN_W + (2 ** SHF_W);

    typedef enum logic {
        SEL_CLOCK = 1'b0,
        SEL_WAVE  = 1'b1
    } reg_sel_e;

    // Control bits, lowest bit first: run, pin, invert, open-drain, sync-off
    typedef struct packed {
        logic sync_off;
        logic open_drain;
        logic invert;
        logic pin_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic [SHF_W-1:0] shift;
        logic [LIN_W-1:0] lin;
    } div_t;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] fall;
        logic [CNT_W-1:0] rise;
    } wave_t;

    typedef struct packed {
        div_t  div;
        wave_t wave;
    } timing_t;

    function automatic logic [PRE_W-1:0] quantum_len(input div_t d);
        logic [PRE_W-1:0] base;
        base = {{(PRE_W-LIN_W){1'b0}}, d.lin} + PRE_W'(1);
        return base << d.shift;
    endfunction

    function automatic logic in_window(input logic [CNT_W-1:0] q,
                                       input logic [CNT_W-1:0] rise,
                                       input logic [CNT_W-1:0] fall);
        if (rise == fall)
            return 1'b1;
        else if (rise < fall)
            return (q >= rise) && (q < fall);
        else
            return (q >= rise) || (q < fall);
    endfunction

endpackage

// File: rtl/pwm_dp_regs.sv
module pwm_dp_regs
    import pwm_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              boundary,
    output ctrl_t             ctrl,
    output timing_t           act
);

    timing_t staged;
    timing_t staged_d;
    ctrl_t   ctrl_d;
    logic    load_act;

    always_comb begin
        staged_d = staged;
        ctrl_d   = ctrl;
        if (wr_en && (reg_sel_e'(wr_sel) == SEL_CLOCK)) begin
            staged_d.div = div_t'(wr_data[CTRL_BASE-1:0]);
            ctrl_d       = ctrl_t'(wr_data[CTRL_BASE+CTRL_W-1:CTRL_BASE]);
        end
        if (wr_en && (reg_sel_e'(wr_sel) == SEL_WAVE)) begin
            staged_d.wave = wave_t'(wr_data[WAVE_W-1:0]);
        end
    end

    // Working bank copies the staging bank when stopped, when bypassed, or at a period edge
    assign load_act = !ctrl_d.run || ctrl_d.sync_off || boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
            ctrl   <= '0;
            act    <= '0;
        end else begin
            staged <= staged_d;
            ctrl   <= ctrl_d;
            if (load_act)
                act <= staged_d;
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !ctrl.sync_off && !boundary && !wr_en) |=> $stable(act)); // R8

    AST_STOPPED_TRACK: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !wr_en) |=> (act == $past(staged))); // R5

endmodule

// File: rtl/pwm_dp_prescaler.sv
module pwm_dp_prescaler
    import pwm_dp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  div_t div,
    output logic tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    logic             term;

    assign limit = quantum_len(div);
    assign term  = (pre_cnt >= limit - PRE_W'(1));
    assign tick  = run && term;

    always_ff @(posedge clk) begin
        if (rst || !run)
            pre_cnt <= '0;
        else if (term)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_W'(1);
    end

    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_cnt == '0)); // R5

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $stable(div)) |-> (pre_cnt < limit)); // R1

endmodule

// File: rtl/pwm_dp_counter.sv
module pwm_dp_counter
    import pwm_dp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  wave_t            wave,
    output logic [CNT_W-1:0] q,
    output logic             boundary,
    output logic             level
);

    logic last;

    assign last     = (q >= wave.period);
    assign boundary = tick && last;
    assign level    = run && in_window(q, wave.rise, wave.fall);

    always_ff @(posedge clk) begin
        if (rst || !run)
            q <= '0;
        else if (tick)
            q <= last ? '0 : q + CNT_W'(1);
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (q == '0)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !boundary) |=> (!run || (q == $past(q) + CNT_W'(1)))); // R1

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
        (run && (wave.rise == wave.fall)) |-> level); // R4

endmodule

// File: rtl/pwm_dp_outstage.sv
module pwm_dp_outstage
    import pwm_dp_pkg::*;
(
    input  logic  level,
    input  ctrl_t ctrl,
    output logic  pin,
    output logic  oe
);

    logic gated;

    // Order: pin gating, then polarity, then drive style
    assign gated = ctrl.pin_en ? level : 1'b0;
    assign pin   = gated ^ ctrl.invert;
    assign oe    = ctrl.pin_en && !(ctrl.open_drain && pin);

endmodule

// File: rtl/pwm_dual_point_ch.sv
module pwm_dual_point_ch
    import pwm_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_o,
    output logic              pwm_oe_o,
    output logic              stat_level_o
);

    ctrl_t            ctrl;
    timing_t          act;
    logic             tick;
    logic             boundary;
    logic             level;
    logic [CNT_W-1:0] q;

    pwm_dp_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .boundary (boundary),
        .ctrl     (ctrl),
        .act      (act)
    );

    pwm_dp_prescaler pre_i (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .div  (act.div),
        .tick (tick)
    );

    pwm_dp_counter cnt_i (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .tick     (tick),
        .wave     (act.wave),
        .q        (q),
        .boundary (boundary),
        .level    (level)
    );

    pwm_dp_outstage out_i (
        .level (level),
        .ctrl  (ctrl),
        .pin   (pwm_o),
        .oe    (pwm_oe_o)
    );

    assign stat_level_o = level;

    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.open_drain && pwm_oe_o) |-> !pwm_o); // R10

    AST_PIN_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.pin_en |-> (!pwm_oe_o && (pwm_o == ctrl.invert))); // R6

    AST_PUSH_PULL_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pin_en && !ctrl.open_drain) |-> pwm_oe_o); // R11

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> (!ctrl.run || (q == '0))); // R5

endmodule

// File: tb/pwm_dual_point_ch_tb_top.sv
`timescale 1ns/1ps
module pwm_dual_point_ch_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        wr_sel;
    logic [23:0] wr_data;
    logic        pwm_o;
    logic        pwm_oe_o;
    logic        stat_level_o;

    int n_chk  = 0;
    int n_err  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_dual_point_ch dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .pwm_o        (pwm_o),
        .pwm_oe_o     (pwm_oe_o),
        .stat_level_o (stat_level_o)
    );

    function automatic logic [23:0] cfg0(input int dl, input int dh, input bit run,
                                         input bit pin, input bit inv, input bit od,
                                         input bit soff);
        return {7'd0, soff, od, inv, pin, run, 4'(dh), 8'(dl)};
    endfunction

    function automatic logic [23:0] cfg1(input int per, input int fall, input int rise);
        return {8'(per), 8'(fall), 8'(rise)};
    endfunction

    function automatic logic win(input int q, input int r, input int f);
        if (r == f)     return 1'b1;
        else if (r < f) return (q >= r) && (q < f);
        else            return (q >= r) || (q < f);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; the write lands at the next posedge; returns at the following negedge
    task automatic wr(input logic sel, input logic [23:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run_case(input int dl, input int dh, input int per,
                            input int r, input int f, input bit inv);
        int qlen;
        wr(1'b0, cfg0(dl, dh, 0, 0, 0, 0, 0));
        wr(1'b1, cfg1(per, f, r));
        wr(1'b0, cfg0(dl, dh, 1, 1, inv, 0, 0));
        qlen = (dl + 1) << dh;
        for (int k = 0; k < 2 * (per + 1) * qlen; k++) begin
            int q;
            q = (k / qlen) % (per + 1);
            if (r == f) chk("R4 R1 R2", pwm_o, 1'b1 ^ inv);
            else        chk("R3 R1 R2", pwm_o, win(q, r, f) ^ inv);
            if (k == 0) chk("R11", pwm_oe_o, 1'b1);
            @(negedge clk);
        end
    endtask

    task automatic shadow_case(input bit soff);
        wr(1'b0, cfg0(0, 0, 0, 0, 0, 0, soff));
        wr(1'b1, cfg1(7, 2, 0));
        wr(1'b0, cfg0(0, 0, 1, 1, 0, 0, soff));
        repeat (3) @(negedge clk);                     // k = 3
        wr(1'b1, cfg1(7, 6, 0));                       // k = 4
        chk(soff ? "R9" : "R8", pwm_o, soff);
        @(negedge clk);                                // k = 5
        chk(soff ? "R9" : "R8", pwm_o, soff);
        repeat (8) @(negedge clk);                     // k = 13, q = 5
        chk(soff ? "R9" : "R8", pwm_o, 1'b1);
        @(negedge clk);                                // k = 14, q = 6
        chk(soff ? "R9" : "R8", pwm_o, 1'b0);
    endtask

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_sel  = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk("R12", pwm_o, 1'b0);
        chk("R12", pwm_oe_o, 1'b0);
        chk("R12", stat_level_o, 1'b0);

        // R1..R4 sweep over small divisors, periods and every point pair
        for (int dl = 0; dl <= 2; dl += 2)
            for (int dh = 0; dh < 2; dh++)
                for (int per = 2; per <= 3; per++)
                    for (int r = 0; r <= per; r++)
                        for (int f = 0; f <= per; f++)
                            run_case(dl, dh, per, r, f, bit'((r + f) % 2));
        run_case(4, 2, 1, 0, 1, 1'b0);                 // R1: quantum of 20 cycles

        // R5: stopped counter keeps the level low; staged values apply on start
        wr(1'b0, cfg0(0, 0, 0, 1, 0, 0, 0));
        wr(1'b1, cfg1(3, 0, 0));
        for (int i = 0; i < 4; i++) begin
            chk("R5", pwm_o, 1'b0);
            chk("R5", stat_level_o, 1'b0);
            @(negedge clk);
        end
        wr(1'b1, cfg1(3, 2, 1));                        // window 1..1 -> q=0 low
        wr(1'b0, cfg0(0, 0, 1, 1, 0, 0, 0));
        chk("R5", stat_level_o, 1'b0);                  // q = 0
        @(negedge clk);
        chk("R5", stat_level_o, 1'b1);                  // q = 1

        // R6, R7, R10, R11 with a full-duty waveform
        wr(1'b0, cfg0(0, 0, 0, 0, 0, 0, 0));
        wr(1'b1, cfg1(3, 1, 1));
        wr(1'b0, cfg0(0, 0, 1, 1, 0, 0, 0));
        chk("R11", pwm_o, 1'b1);
        chk("R11", pwm_oe_o, 1'b1);
        wr(1'b0, cfg0(0, 0, 1, 0, 0, 0, 0));
        chk("R6", pwm_o, 1'b0);
        chk("R6", pwm_oe_o, 1'b0);
        chk("R6", stat_level_o, 1'b1);
        wr(1'b0, cfg0(0, 0, 1, 0, 1, 0, 0));
        chk("R6", pwm_o, 1'b1);
        chk("R6", pwm_oe_o, 1'b0);
        wr(1'b0, cfg0(0, 0, 1, 1, 1, 0, 0));
        chk("R7", pwm_o, 1'b0);
        chk("R11", pwm_oe_o, 1'b1);
        wr(1'b0, cfg0(0, 0, 1, 1, 0, 1, 0));
        chk("R10", pwm_o, 1'b1);
        chk("R10", pwm_oe_o, 1'b0);
        wr(1'b0, cfg0(0, 0, 1, 1, 1, 1, 0));
        chk("R10", pwm_o, 1'b0);
        chk("R10", pwm_oe_o, 1'b1);

        // R7: invert mid-period shows at once
        wr(1'b0, cfg0(0, 0, 0, 0, 0, 0, 0));
        wr(1'b1, cfg1(7, 4, 0));
        wr(1'b0, cfg0(0, 0, 1, 1, 0, 0, 0));           // k = 0
        @(negedge clk);                                // k = 1
        chk("R7", pwm_o, 1'b1);
        wr(1'b0, cfg0(0, 0, 1, 1, 1, 0, 0));           // k = 2, q = 2, level 1
        chk("R7", pwm_o, 1'b0);

        // R8 and R9: staged versus immediate waveform updates
        shadow_case(1'b0);
        shadow_case(1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule